// File: doc/BRIEF.md
# I/Q Block-Floating-Point Output Formatter

This block takes a stream of signed 24-bit I/Q sample pairs from a filter stage and reformats each pair into one of three output packings. The packings are a saturated 16-bit fixed-point window, a 12-bit word made of an 8-bit mantissa and a 4-bit exponent, and a 16-bit word made of a 12-bit mantissa and a 4-bit exponent. In every packing the exponent is a right-shift count. In the floating-point packings that count is normally chosen per component as the smallest shift that keeps the mantissa in range.

Two static controls change how the exponent is chosen. A force control replaces the automatic choice with a programmed 4-bit scale value, so the output range stays predictable. A share control makes I and Q use one common exponent. That exponent is the larger of the two automatic choices, so neither component overflows, and the smaller one loses some low-order precision.

Each input pair comes with a valid strobe. The formatted pair appears one clock later with its own valid strobe. The control fields are captured only together with a valid input.

Top module: `iq_fp_formatter`

## Requirements
- R1: With fmt_mode = 00 each output is the input arithmetically shifted right by fix_scale, then saturated to a signed 16-bit value (range -32768..32767).
- R2: With fmt_mode = 01 each output word is {4'b0000, mantissa[7:0], exponent[3:0]}, with the mantissa an 8-bit signed value.
- R3: With fmt_mode = 10 or 11 each output word is {mantissa[11:0], exponent[3:0]}, with the mantissa a 12-bit signed value; the low bit of fmt_mode has no effect.
- R4: With force_scale = 0 and share_exp = 0, each component's exponent is the smallest shift in 0..15 at which the shifted value fits the signed mantissa width. When no shift up to 15 fits, the exponent is 15.
- R5: With force_scale = 1 in a floating-point mode, the exponent of both components equals fix_scale.
- R6: With share_exp = 1 and force_scale = 0 in a floating-point mode, both components use the larger of their two automatic exponents.
- R7: Every shift rounds toward negative infinity, with no rounding bias. A mantissa that is still out of range after its shift saturates to the most positive or most negative mantissa.
- R8: out_valid equals in_valid delayed by one clock. While no valid input arrives, out_i and out_q hold their values.
- R9: While rst_n is low, out_valid, out_i and out_q are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pair qualifier |
| in_i | input | 24 | In-phase sample, signed |
| in_q | input | 24 | Quadrature sample, signed |
| fmt_mode | input | 2 | Output packing: 00 fixed, 01 8+4, 1x 12+4 |
| fix_scale | input | 4 | Fixed-point shift, or forced exponent |
| force_scale | input | 1 | Use fix_scale as the floating-point exponent |
| share_exp | input | 1 | One common exponent for I and Q |
| out_valid | output | 1 | Output pair qualifier |
| out_i | output | 16 | Formatted in-phase word |
| out_q | output | 16 | Formatted quadrature word |

## Verification
Random 24-bit pairs are drawn at several magnitudes: full scale, around 2^12 and below 2^7. This makes the automatic exponent land at zero, at mid-range values and at its saturation limit. Directed pairs then separate the individual effects. Values exactly at a mantissa boundary (127, 128, -128, -129) show whether the exponent is the smallest fitting shift. Small negative odd values show whether the shift truncates toward negative infinity. A large I with a tiny Q shows whether the shared exponent is the larger of the two. A forced scale too small for the input shows whether the mantissa saturates.

// File: rtl/iq_fmt_pkg.sv
`timescale 1ns/1ps
package iq_fmt_pkg;
  parameter int IQ_IN_W  = 24;
  parameter int IQ_OUT_W = 16;
  parameter int IQ_EXP_W = 4;
  parameter int IQ_MAN_N = 8;
  parameter int IQ_MAN_W = 12;

  typedef enum logic [1:0] {
    PK_FIXED = 2'b00,
    PK_FP8   = 2'b01,
    PK_FP12  = 2'b10
  } pack_e;

  function automatic pack_e decode_mode(input logic [1:0] m);
    case (m)
      2'b00:   return PK_FIXED;
      2'b01:   return PK_FP8;
      default: return PK_FP12;
    endcase
  endfunction

  // arithmetic right shift (floor), then clamp to a signed field of w bits
  function automatic int shift_clamp(input logic signed [IQ_IN_W-1:0] x,
                                     input int sh, input int w);
    int y;
    int hi;
    int lo;
    y  = int'(x >>> sh);
    hi = (1 << (w - 1)) - 1;
    lo = -hi - 1;
    if (y > hi) y = hi;
    if (y < lo) y = lo;
    return y;
  endfunction

  function automatic logic shift_fits(input logic signed [IQ_IN_W-1:0] x,
                                      input int sh, input int w);
    int y;
    y = int'(x >>> sh);
    return (y <= (1 << (w - 1)) - 1) && (y >= -(1 << (w - 1)));
  endfunction

  // smallest shift in 0..(2^EXP_W-1) that fits w bits; saturates at the top
  function automatic logic [IQ_EXP_W-1:0] best_shift(input logic signed [IQ_IN_W-1:0] x,
                                                     input int w);
    logic [IQ_EXP_W-1:0] e;
    logic found;
    e = '1;
    found = 1'b0;
    for (int s = 0; s < (1 << IQ_EXP_W); s++) begin
      if (!found && shift_fits(x, s, w)) begin
        e = IQ_EXP_W'(s);
        found = 1'b1;
      end
    end
    return e;
  endfunction
endpackage

// File: rtl/iq_exp_pick.sv
`timescale 1ns/1ps
module iq_exp_pick
  import iq_fmt_pkg::*;
#(
  parameter int IN_W  = IQ_IN_W,
  parameter int EXP_W = IQ_EXP_W,
  parameter int MAN_N = IQ_MAN_N,
  parameter int MAN_W = IQ_MAN_W
) (
  input  logic signed [IN_W-1:0] x,
  input  logic                   wide_man,
  output logic [EXP_W-1:0]       exp_auto
);
  logic [EXP_W-1:0] exp_narrow;
  logic [EXP_W-1:0] exp_wide;

  always_comb begin
    exp_narrow = best_shift(x, MAN_N);
    exp_wide   = best_shift(x, MAN_W);
    exp_auto   = wide_man ? exp_wide : exp_narrow;
  end
endmodule

// File: rtl/iq_word_pack.sv
`timescale 1ns/1ps
module iq_word_pack
  import iq_fmt_pkg::*;
#(
  parameter int IN_W  = IQ_IN_W,
  parameter int OUT_W = IQ_OUT_W,
  parameter int EXP_W = IQ_EXP_W,
  parameter int MAN_N = IQ_MAN_N,
  parameter int MAN_W = IQ_MAN_W
) (
  input  logic signed [IN_W-1:0] x,
  input  pack_e                  pk,
  input  logic [EXP_W-1:0]       fix_shift,
  input  logic [EXP_W-1:0]       exp_use,
  output logic [OUT_W-1:0]       word
);
  localparam int PAD_N = OUT_W - MAN_N - EXP_W;

  int fix_val;
  int man_val;
  logic [OUT_W-1:0] fix_bits;
  logic [OUT_W-1:0] man_bits;

  always_comb begin
    fix_val  = shift_clamp(x, int'(fix_shift), OUT_W);
    man_val  = shift_clamp(x, int'(exp_use), (pk == PK_FP8) ? MAN_N : MAN_W);
    fix_bits = OUT_W'(fix_val);
    man_bits = OUT_W'(man_val);
    case (pk)
      PK_FIXED: word = fix_bits;
      PK_FP8:   word = {{PAD_N{1'b0}}, man_bits[MAN_N-1:0], exp_use};
      default:  word = {man_bits[MAN_W-1:0], exp_use};
    endcase
  end
endmodule

// File: rtl/iq_fp_formatter.sv
`timescale 1ns/1ps
module iq_fp_formatter
  import iq_fmt_pkg::*;
#(
  parameter int IN_W  = IQ_IN_W,
  parameter int OUT_W = IQ_OUT_W,
  parameter int EXP_W = IQ_EXP_W,
  parameter int MAN_N = IQ_MAN_N,
  parameter int MAN_W = IQ_MAN_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_i,
  input  logic signed [IN_W-1:0]  in_q,
  input  logic [1:0]              fmt_mode,
  input  logic [EXP_W-1:0]        fix_scale,
  input  logic                    force_scale,
  input  logic                    share_exp,
  output logic                    out_valid,
  output logic [OUT_W-1:0]        out_i,
  output logic [OUT_W-1:0]        out_q
);
  localparam int NCH = 2;

  pack_e                   pk;
  logic signed [IN_W-1:0]  comp     [NCH];
  logic [EXP_W-1:0]        exp_auto [NCH];
  logic [EXP_W-1:0]        exp_use  [NCH];
  logic [OUT_W-1:0]        word     [NCH];
  logic [EXP_W-1:0]        exp_common;

  always_comb begin
    pk      = decode_mode(fmt_mode);
    comp[0] = in_i;
    comp[1] = in_q;
  end

  // common exponent: the larger shift keeps both components in range
  assign exp_common = (exp_auto[0] > exp_auto[1]) ? exp_auto[0] : exp_auto[1];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    iq_exp_pick #(
      .IN_W(IN_W), .EXP_W(EXP_W), .MAN_N(MAN_N), .MAN_W(MAN_W)
    ) u_pick (
      .x        (comp[c]),
      .wide_man (pk == PK_FP12),
      .exp_auto (exp_auto[c])
    );

    always_comb begin
      if (force_scale)    exp_use[c] = fix_scale;
      else if (share_exp) exp_use[c] = exp_common;
      else                exp_use[c] = exp_auto[c];
    end

    iq_word_pack #(
      .IN_W(IN_W), .OUT_W(OUT_W), .EXP_W(EXP_W), .MAN_N(MAN_N), .MAN_W(MAN_W)
    ) u_pack (
      .x         (comp[c]),
      .pk        (pk),
      .fix_shift (fix_scale),
      .exp_use   (exp_use[c]),
      .word      (word[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_i <= word[0];
        out_q <= word[1];
      end
    end
  end
endmodule

// File: rtl/iq_fmt_checker.sv
`timescale 1ns/1ps
module iq_fmt_checker #(
  parameter int OUT_W = 16,
  parameter int EXP_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       fmt_mode,
  input logic [EXP_W-1:0] fix_scale,
  input logic             force_scale,
  input logic             share_exp,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_i,
  input logic [OUT_W-1:0] out_q
);
  a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid));

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> ($stable(out_i) && $stable(out_q)));

  a_r5_forced_exp: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && force_scale && fmt_mode != 2'b00) |->
      (out_i[EXP_W-1:0] == $past(fix_scale) && out_q[EXP_W-1:0] == $past(fix_scale)));

  a_r6_shared_exp: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && share_exp && fmt_mode != 2'b00) |->
      out_i[EXP_W-1:0] == out_q[EXP_W-1:0]);

  a_r2_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && fmt_mode == 2'b01) |->
      (out_i[OUT_W-1:OUT_W-4] == 4'h0 && out_q[OUT_W-1:OUT_W-4] == 4'h0));
endmodule

bind iq_fp_formatter iq_fmt_checker #(.OUT_W(OUT_W), .EXP_W(EXP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_mode(fmt_mode),
  .fix_scale(fix_scale), .force_scale(force_scale), .share_exp(share_exp),
  .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
);

// File: tb/sim_iq_fp_formatter.sv
`timescale 1ns/1ps
module sim_iq_fp_formatter;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic signed [23:0] in_i = '0;
  logic signed [23:0] in_q = '0;
  logic [1:0]         fmt_mode = 2'b00;
  logic [3:0]         fix_scale = 4'd0;
  logic               force_scale = 1'b0;
  logic               share_exp = 1'b0;
  logic               out_valid;
  logic [15:0]        out_i;
  logic [15:0]        out_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2ns clk = ~clk;

  iq_fp_formatter u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .fmt_mode(fmt_mode), .fix_scale(fix_scale), .force_scale(force_scale),
    .share_exp(share_exp), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  // floor division by 2^s, stated through integer division with a correction
  function automatic longint floor_pow2(input longint v, input int s);
    longint p;
    longint r;
    p = longint'(1) << s;
    r = v / p;
    if (v < 0 && (v % p) != 0) r = r - 1;
    return r;
  endfunction

  function automatic longint clip(input longint v, input int bits);
    longint top;
    top = (longint'(1) << (bits - 1)) - 1;
    if (v > top) return top;
    if (v < -top - 1) return -top - 1;
    return v;
  endfunction

  function automatic int ref_exp(input longint v, input int bits);
    for (int s = 0; s <= 15; s++) begin
      if (clip(floor_pow2(v, s), bits) == floor_pow2(v, s)) return s;
    end
    return 15;
  endfunction

  function automatic logic [15:0] ref_word(input longint v, input logic [1:0] md,
                                           input int sc, input int ex);
    longint m;
    if (md == 2'b00) return 16'(clip(floor_pow2(v, sc), 16));
    if (md == 2'b01) begin
      m = clip(floor_pow2(v, ex), 8);
      return {4'h0, 8'(m), 4'(ex)};
    end
    m = clip(floor_pow2(v, ex), 12);
    return {12'(m), 4'(ex)};
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic send(input string tag, input longint vi, input longint vq,
                      input logic [1:0] md, input int sc, input bit frc, input bit shr);
    int bits;
    int ei;
    int eq;
    int mx;
    bits = (md == 2'b01) ? 8 : 12;
    ei = ref_exp(vi, bits);
    eq = ref_exp(vq, bits);
    mx = (ei > eq) ? ei : eq;
    if (frc) begin ei = sc; eq = sc; end
    else if (shr) begin ei = mx; eq = mx; end
    @(negedge clk);
    in_i = 24'(vi); in_q = 24'(vq);
    fmt_mode = md; fix_scale = 4'(sc); force_scale = frc; share_exp = shr;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R8 valid"}, {15'd0, out_valid}, 16'd1);
    check({tag, " I"}, out_i, ref_word(vi, md, sc, ei));
    check({tag, " Q"}, out_q, ref_word(vq, md, sc, eq));
  endtask

  function automatic longint rnd_val(input int mag);
    longint v;
    v = longint'($urandom) % (longint'(1) << mag);
    if ($urandom % 2 == 1) v = -v - 1;
    return v;
  endfunction

  initial begin
    #(200000 * 4ns);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] hi_snap;
    logic [15:0] hq_snap;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset valid", {15'd0, out_valid}, 16'd0);
    check("R9 reset I", out_i, 16'd0);
    check("R9 reset Q", out_q, 16'd0);
    rst_n = 1'b1;

    // R1 fixed window with saturation
    send("R1 fix sat", 24'sd100000, -100000, 2'b00, 0, 1'b0, 1'b0);
    send("R1 fix shift", 24'sd100000, -100000, 2'b00, 3, 1'b0, 1'b0);
    // R4 mantissa boundaries, 8-bit
    send("R4 edge8", 127, -128, 2'b01, 0, 1'b0, 1'b0);
    send("R4 over8", 128, -129, 2'b01, 0, 1'b0, 1'b0);
    // R4 exponent saturation at 15
    send("R4 sat15", 8388607, -8388608, 2'b01, 0, 1'b0, 1'b0);
    // R3 low mode bit has no effect
    send("R3 mode10", 5000, -3001, 2'b10, 0, 1'b0, 1'b0);
    send("R3 mode11", 5000, -3001, 2'b11, 0, 1'b0, 1'b0);
    // R7 truncation toward minus infinity
    send("R7 floor", -3, -5, 2'b00, 1, 1'b0, 1'b0);
    send("R7 floor fp", -257, 257, 2'b01, 0, 1'b0, 1'b0);
    // R6 shared exponent, big I and tiny Q
    send("R6 share", 2000000, 3, 2'b10, 0, 1'b0, 1'b1);
    send("R6 share8", -5, 70000, 2'b01, 0, 1'b0, 1'b1);
    // R5 forced exponent with saturation of mantissa
    send("R5 force sat", 2000000, -2000000, 2'b10, 2, 1'b1, 1'b0);
    send("R5 force", 4096, -77, 2'b01, 9, 1'b1, 1'b1);
    send("R2 pack8", 1000, -1000, 2'b01, 0, 1'b0, 1'b0);

    // R8 idle: outputs hold, valid low
    hi_snap = out_i;
    hq_snap = out_q;
    @(negedge clk);
    in_i = 24'sd12345; in_q = -24'sd999; fmt_mode = 2'b00;
    @(negedge clk);
    check("R8 idle valid", {15'd0, out_valid}, 16'd0);
    check("R8 hold I", out_i, hi_snap);
    check("R8 hold Q", out_q, hq_snap);

    // random mix over magnitudes and controls
    for (int n = 0; n < 300; n++) begin
      int mags[3];
      mags = '{23, 13, 7};
      send("R4 rnd", rnd_val(mags[$urandom % 3]), rnd_val(mags[$urandom % 3]),
           2'($urandom), int'($urandom % 16), ($urandom % 4) == 0, ($urandom % 3) == 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule